// File: doc/BRIEF.md
# Interrupt Bit to Priority-Level Mapper

This block sits between eight single-bit interrupt sources and a processor that takes interrupts as a vector of priority levels. Each source is level-sensitive and is sampled every clock into a pending register. A fixed, sparse table turns each pending bit into one processor level. Bit 0 goes to no level, bit 1 to level 1, bit 2 to level 4, bit 3 to level 6, bit 4 to level 8, bit 5 to level 10, bit 6 to no level and bit 7 to level 14. The level vector is the OR of the levels of all pending bits. It is registered and is 16 bits wide, with line 0 never driven.

A byte-wide control register is written with `wr_en` and `wr_data`, and it is always visible on `rd_data`. Bit 0 of that register is the global gate: 1 lets levels through, and 0 holds every level line low whatever is pending. Reset clears the control register and the pending register, so the outputs come up low and interrupts come up disabled. Software then writes bit 0 to 1 to open the gate.

Top module: `irq_level_mapper`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `level_out` is 0 and `rd_data` is 0.
- R2: A cycle with `wr_en` high stores all 8 bits of `wr_data` in the control register. `rd_data` shows the stored byte from the next cycle onward and holds it until the next write.
- R3: Each pending bit follows its source input with one register stage, and nothing is latched. When a source drops, its level falls unless another pending bit maps to the same level.
- R4: With the gate open and one source `k` held high, `level_out` is one-hot at bit position table[k], where table = {0,1,4,6,8,10,0,14} for k = 0..7. For k = 0 and k = 6, `level_out` is 0.
- R5: With several sources high, `level_out` is the bitwise OR of the one-hot vectors of the individual sources.
- R6: When control bit 0 is 0, `level_out` is 0 whatever is pending. Control bits 7..1 have no effect on `level_out`.
- R7: A source change sampled at clock edge N shows on `level_out` after edge N+1. A control write at edge N shows on `level_out` after edge N+1. When both fall in the same cycle, both are visible together after that edge.
- R8: `level_out[0]` is always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Byte to store in the control register |
| rd_data | output | 8 | Current control register value |
| src_in | input | 8 | Level-sensitive interrupt sources, bit k is source k |
| level_out | output | 16 | Registered processor level vector, bit n is level n |

## Verification
A control write and a change of the sources can land in the same cycle. Because both reach `level_out` through the same output register, an error in either path shows in the same sample. The bench provokes this by raising a source on the same clock that opens the gate, by opening the gate while a source that maps to no level is raised, and by closing the gate on the cycle a new source arrives. After the second edge it compares `level_out` with the level the table gives for the new sources under the new gate value. It also samples once between the two edges to confirm that the output still shows the old state.

// File: rtl/irqmap_pkg.sv
package irqmap_pkg;
  localparam int NUM_SRC = 8;
  localparam int LEVEL_W = 16;
  localparam int CTRL_W  = 8;
  localparam int LID_W   = $clog2(LEVEL_W);

  // Fixed source-bit to processor-level table; level 0 means "no line".
  function automatic logic [LID_W-1:0] src_to_level(input logic [2:0] idx);
    case (idx)
      3'd0:    return LID_W'(0);
      3'd1:    return LID_W'(1);
      3'd2:    return LID_W'(4);
      3'd3:    return LID_W'(6);
      3'd4:    return LID_W'(8);
      3'd5:    return LID_W'(10);
      3'd6:    return LID_W'(0);
      default: return LID_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
  parameter int W      = 8,
  parameter int EN_BIT = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] ctrl_q,
  output logic         enable
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
      if (wr_en) ctrl_q <= wr_data;
    end
  end

  assign enable = ctrl_q[EN_BIT];

  // R2: a write is stored in full, otherwise the value holds
  p_ctrl_store_r2: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(wr_en) |-> ctrl_q == $past(wr_data));
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(wr_en) |-> $stable(ctrl_q));
endmodule

// File: rtl/irq_pending.sv
module irq_pending #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  output logic [N-1:0] pend_q
);
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      pend_q  <= src_in;
      armed_q <= 1'b1;
    end
  end

  // R3: pending tracks the sources one cycle late, no latching
  p_follow_r3: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> pend_q == $past(src_in));
endmodule

// File: rtl/irq_level_xlate.sv
module irq_level_xlate
  import irqmap_pkg::*;
#(
  parameter int N  = NUM_SRC,
  parameter int LW = LEVEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  pend,
  input  logic          enable,
  output logic [LW-1:0] level_out
);
  logic [LW-1:0] level_nxt;
  logic          armed_q;

  for (genvar L = 0; L < LW; L++) begin : g_lvl
    if (L == 0) begin : g_none
      assign level_nxt[L] = 1'b0;
    end else begin : g_map
      always_comb begin
        level_nxt[L] = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (pend[i] && (src_to_level(3'(i)) == LID_W'(L)))
            level_nxt[L] = 1'b1;
        end
        if (!enable) level_nxt[L] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_out <= '0;
      armed_q   <= 1'b0;
    end else begin
      level_out <= level_nxt;
      armed_q   <= 1'b1;
    end
  end

  // R6: a closed gate leaves every level low on the next cycle
  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    armed_q && !$past(enable) |-> level_out == '0);
  // R8: level line 0 never rises
  p_level0_idle_r8: assert property (@(posedge clk) disable iff (rst)
    level_out[0] == 1'b0);
  // R4: a single pending source drives at most one line
  p_single_r4: assert property (@(posedge clk) disable iff (rst)
    armed_q && $countones($past(pend)) == 1 |-> $countones(level_out) <= 1);
  // R5: no level without something pending
  p_none_r5: assert property (@(posedge clk) disable iff (rst)
    armed_q && $past(pend) == '0 |-> level_out == '0);
endmodule

// File: rtl/irq_level_mapper.sv
module irq_level_mapper
  import irqmap_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [CTRL_W-1:0]  wr_data,
  output logic [CTRL_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [LEVEL_W-1:0] level_out
);
  logic [NUM_SRC-1:0] pend;
  logic               enable;

  irq_ctrl_reg #(.W(CTRL_W), .EN_BIT(0)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .ctrl_q(rd_data), .enable(enable)
  );

  irq_pending #(.N(NUM_SRC)) u_pend (
    .clk(clk), .rst(rst), .src_in(src_in), .pend_q(pend)
  );

  irq_level_xlate #(.N(NUM_SRC), .LW(LEVEL_W)) u_xlate (
    .clk(clk), .rst(rst), .pend(pend), .enable(enable), .level_out(level_out)
  );
endmodule

// File: tb/irq_level_mapper_tb.sv
`timescale 1ns/1ps
module irq_level_mapper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;
  logic [7:0]  src_in = 8'h00;
  logic [15:0] level_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] q_lvl[$];
  logic [7:0]  q_rd[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  irq_level_mapper u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_in(src_in), .level_out(level_out)
  );

  function automatic int lvl_of(int k);
    int t[8] = '{0, 1, 4, 6, 8, 10, 0, 14};
    return t[k];
  endfunction

  function automatic logic [15:0] expect_lvl(logic [7:0] s, logic [7:0] c);
    logic [15:0] v = '0;
    if (!c[0]) return '0;
    for (int k = 0; k < 8; k++)
      if (s[k] && lvl_of(k) != 0) v[lvl_of(k)] = 1'b1;
    return v;
  endfunction

  task automatic check(string tag, logic [15:0] al, logic [15:0] el,
                       logic [7:0] ar, logic [7:0] er);
    checks++;
    if (al !== el || ar !== er) begin
      errors++;
      $display("FAIL %s level_out=%h expected %h rd_data=%h expected %h",
               tag, al, el, ar, er);
    end
  endtask

  logic [7:0] m_ctrl = 8'h00;

  // driver: apply one stimulus, push the expected result after two edges
  task automatic step(logic [7:0] s, bit wr, logic [7:0] d, string tag);
    @(negedge clk);
    src_in  = s;
    wr_en   = wr;
    wr_data = d;
    if (wr) m_ctrl = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    @(posedge clk);
    #1;
    q_lvl.push_back(expect_lvl(s, m_ctrl));
    q_rd.push_back(m_ctrl);
    q_tag.push_back(tag);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (q_lvl.size() > 0)
      check(q_tag.pop_front(), level_out, q_lvl.pop_front(), rd_data, q_rd.pop_front());
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    src_in = 8'hFF;
    check("R1 in reset", level_out, 16'h0, rd_data, 8'h00);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 after reset", level_out, 16'h0, rd_data, 8'h00);

    step(8'h00, 1'b1, 8'h01, "R2 enable write");
    for (int k = 0; k < 8; k++) begin
      step(8'h01 << k, 1'b0, 8'h00, $sformatf("R4 R8 single source %0d", k));
      step(8'h00, 1'b0, 8'h00, "R3 release");
    end
    step(8'hA6, 1'b0, 8'h00, "R5 mixed sources");
    step(8'hFF, 1'b0, 8'h00, "R5 all sources");
    step(8'h41, 1'b0, 8'h00, "R5 R8 unmapped pair");
    step(8'h30, 1'b0, 8'h00, "R3 drop to subset");
    step(8'hFF, 1'b1, 8'hFE, "R6 gate closed upper bits set");
    step(8'h0F, 1'b1, 8'h81, "R6 R2 gate reopened");
    step(8'h80, 1'b1, 8'h00, "R7 close with new source");
    step(8'h04, 1'b1, 8'h01, "R7 open with new source");
    step(8'h40, 1'b1, 8'h01, "R7 open with unmapped source");

    // R7: between the two edges the old value is still shown
    @(negedge clk);
    src_in = 8'h08;
    @(posedge clk);
    @(negedge clk);
    check("R7 no change after one edge", level_out, 16'h0000, rd_data, 8'h01);
    @(posedge clk);
    @(negedge clk);
    check("R7 change after second edge", level_out, 16'h0040, rd_data, 8'h01);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule